// File: doc/BRIEF.md
# SD Host Wrapper Register Block

This block is the shared register front end placed ahead of one or two SD host controller slots. It decodes a 32-bit request/response register bus over a 4 KiB address window. The lowest 256 bytes hold the global registers:

- an information register with a self-clearing reset request and read-only slot-presence flags;
- a debounce setting;
- a bus setting;
- a write-protect polarity word;
- a card-detect word;
- a read-only interrupt status word that follows each slot's interrupt line.

Four fixed alias offsets give software direct access to each slot's capability word and maximum-current word. These words are held here and exported to the slots.

Each slot owns a 256-byte register window placed above the global page. A request that lands in a slot window raises that slot's select line and is answered by the slot, not by this block. The slot interrupt lines are captured into the status word. The captured bits are merged into one interrupt output, which stays high while any slot still requests service.

Top module: `sdhost_glue_regs`

## Requirements
- R1: After reset the following values hold:
  - information register (0x00) reads 0x0001_0000 for one slot, or 0x0003_0000 for two slots;
  - debounce (0x04) reads 0x0000_0005;
  - bus (0x08), write-protect polarity (0xEC), card detect (0xF0) and interrupt status (0xFC) read zero;
  - each slot's capability word reads `CAP_RESET`;
  - each slot's maximum-current word reads zero.
- R2: Full 32-bit writes to debounce (0x04), bus (0x08), write-protect polarity (0xEC) and card detect (0xF0) store all 32 bits. A later read returns the stored value, and the matching `cfg_*` output shows it.
- R3: Bit 0 of the information register is a reset request. A write with bit 0 set raises `host_rst_pulse` for exactly one cycle, in the same cycle as that write's response. Bit 0 always reads back as 0.
- R4: Bits 16 and 17 of the information register are read-only slot-presence flags. Bit 16 is always 1. Bit 17 is 1 only when `NUM_SLOTS` is 2. Writes to these bits have no effect. The other bits, 31:18 and 15:1, are ordinary storage.
- R5: The alias offsets read and write the exported slot words, and each write updates the matching slice of `slot_cap_o` / `slot_cur_o`:
  - 0x10 is slot 0's capability word;
  - 0x18 is slot 0's maximum-current word;
  - 0x20 is slot 1's capability word;
  - 0x28 is slot 1's maximum-current word.
  When `NUM_SLOTS` is 1, 0x20 and 0x28 are undecoded.
- R6: A full, aligned request to 0x100–0x1FF raises `slot_sel[0]`, and one to 0x200–0x2FF raises `slot_sel[1]` (the latter only when `NUM_SLOTS` is 2). The select is raised in the same cycle as `req_valid`. At most one select is high at a time. Such a request gets no `rsp_ready` from this block and changes no global register.
- R7: Bit n of the interrupt status word (0xFC) equals slot n's interrupt input as sampled one clock earlier. Bits at or above `NUM_SLOTS` read 0. Writes to 0xFC are accepted without error and have no effect.
- R8: `irq_out` is high exactly when at least one interrupt status bit is set.
- R9: A request whose byte strobe `req_strb` is not 4'hF, or whose address has bits 1:0 non-zero, is rejected:
  - no register changes;
  - read data is zero;
  - `rsp_err` is high with `rsp_ready`;
  - no slot select is raised.
- R10: Any other request that reaches no register is answered with zero read data and `rsp_err` high for one cycle, and the write is dropped. This covers undecoded offsets in 0x00–0xFF, the pages from 0x300 up, and a slot-1 page or alias when only one slot exists.
- R11: Every request not routed to a slot is answered exactly one cycle later:
  - `rsp_ready` is high for one cycle;
  - `rsp_rdata` is valid in that same cycle;
  - `rsp_rdata` is zero for writes.
  Without a request, `rsp_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the 4 KiB window |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte strobes; only 4'hF is accepted |
| rsp_ready | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` |
| rsp_err | output | 1 | Request rejected or undecoded |
| slot_sel | output | NUM_SLOTS | Slot window select, same cycle as request |
| slot_irq | input | NUM_SLOTS | Per-slot interrupt level |
| irq_out | output | 1 | Merged interrupt |
| host_rst_pulse | output | 1 | One-cycle reset request to the slots |
| slot_cap_o | output | 32*NUM_SLOTS | Capability word per slot, slot 0 in the low bits |
| slot_cur_o | output | 32*NUM_SLOTS | Maximum-current word per slot, slot 0 in the low bits |
| cfg_debounce | output | 32 | Debounce register value |
| cfg_bus | output | 32 | Bus register value |
| cfg_wp_pol | output | 32 | Write-protect polarity value |
| cfg_card_det | output | 32 | Card-detect register value |

## Verification
The bench attacks the information register with all-ones, all-zeros and bit-0-only writes:
- a design that stores bit 0 would read it back as 1;
- a design that lets writes reach bits 16/17 would lose the presence flags;
- a design that fires the reset pulse on every write to offset 0 would show a pulse where none is due.

The bench reaches each slot through its alias offset and checks both the read-back and the exported slice. A swapped slot index or a cap/current mix-up shows up as wrong data in the other slot.

The bench probes the edges of the slot windows and the first page above them. It also sends partial-strobe and misaligned requests. A design with an off-by-one page compare would raise the wrong select or answer a request the slot owns. A design that ignores the strobes would corrupt the debounce register.

The interrupt checks lower one slot's line while the other stays high, and they write to the status word. A design that latches the status bits, or lets software overwrite them, would leave `irq_out` stuck high or show a status word that no longer tracks the lines.

// File: rtl/sdglue_pkg.sv
// Shared constants and types for the SD host wrapper register block.
// Holds the global register offsets, reset values and the decode result type.
package sdglue_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned ADDR_W    = 12;
    localparam int unsigned MAX_SLOTS = 2;
    localparam int unsigned IDX_W     = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;

    // Global page offsets (byte addresses inside page 0)
    localparam logic [7:0] OFF_INFO  = 8'h00;
    localparam logic [7:0] OFF_DEB   = 8'h04;
    localparam logic [7:0] OFF_BUS   = 8'h08;
    localparam logic [7:0] OFF_WPPOL = 8'hEC;
    localparam logic [7:0] OFF_CDET  = 8'hF0;
    localparam logic [7:0] OFF_IRQST = 8'hFC;

    // Reset values and information-register layout
    localparam logic [REG_W-1:0] DEB_RESET    = 32'h0000_0005;
    localparam int unsigned      INFO_RST_BIT = 0;
    localparam int unsigned      INFO_PRES_LO = 16;
    localparam logic [REG_W-1:0] INFO_RO_MASK = (32'h1 << INFO_RST_BIT)
                                              | (32'h3 << INFO_PRES_LO);

    // What a request decodes to
    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_INFO,
        TGT_DEB,
        TGT_BUS,
        TGT_WPPOL,
        TGT_CDET,
        TGT_IRQST,
        TGT_CAP,
        TGT_CUR,
        TGT_SLOT
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] idx;
        logic             err;
    } dec_t;

    // Presence flags shown in the information register for a slot count
    function automatic logic [REG_W-1:0] presence_bits(input int unsigned nslots);
        logic [REG_W-1:0] v;
        v = '0;
        for (int i = 0; i < int'(MAX_SLOTS); i++) begin
            if (i < int'(nslots)) v[INFO_PRES_LO + i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/sdglue_decode.sv
// Address decoder for the wrapper register block.
// Purely combinational. It classifies a request by its shape (full strobe,
// aligned), its page (global or slot window) and its offset. It assumes
// NUM_SLOTS is 1 or 2, so the slot alias layout fits below offset 0x30.
module sdglue_decode
    import sdglue_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 2
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [3:0]           strb,
    output dec_t                 dec,
    output logic [NUM_SLOTS-1:0] win_hit
);

    localparam logic [3:0] LAST_PAGE  = 4'(NUM_SLOTS);
    localparam logic [1:0] LAST_ALIAS = 2'(NUM_SLOTS);

    logic [3:0] page;
    logic [7:0] off;
    logic       shape_ok;

    assign page     = addr[11:8];
    assign off      = addr[7:0];
    assign shape_ok = (strb == 4'hF) && (addr[1:0] == 2'b00);

    // Map the request to one target, or flag it as an error
    always_comb begin
        dec     = '{tgt: TGT_NONE, idx: '0, err: 1'b0};
        win_hit = '0;
        if (!shape_ok) begin
            dec.err = 1'b1;
        end else if (page == 4'd0) begin
            if (off[7:6] == 2'b00 && off[2:0] == 3'b000 &&
                off[5:4] != 2'b00 && off[5:4] <= LAST_ALIAS) begin
                dec.tgt = off[3] ? TGT_CUR : TGT_CAP;
                dec.idx = IDX_W'(off[5:4] - 2'd1);
            end else begin
                case (off)
                    OFF_INFO:  dec.tgt = TGT_INFO;
                    OFF_DEB:   dec.tgt = TGT_DEB;
                    OFF_BUS:   dec.tgt = TGT_BUS;
                    OFF_WPPOL: dec.tgt = TGT_WPPOL;
                    OFF_CDET:  dec.tgt = TGT_CDET;
                    OFF_IRQST: dec.tgt = TGT_IRQST;
                    default:   dec.err = 1'b1;
                endcase
            end
        end else if (page <= LAST_PAGE) begin
            dec.tgt = TGT_SLOT;
            dec.idx = IDX_W'(page - 4'd1);
            for (int i = 0; i < int'(NUM_SLOTS); i++) begin
                if (page == 4'(i + 1)) win_hit[i] = 1'b1;
            end
        end else begin
            dec.err = 1'b1;
        end
    end

endmodule

// File: rtl/sdglue_slot_cfg.sv
// Per-slot exported configuration: a capability word and a maximum-current word.
// Each word is written through its own strobe. It assumes the caller raises at
// most one strobe per cycle for this slot.
module sdglue_slot_cfg
    import sdglue_pkg::*;
#(
    parameter logic [REG_W-1:0] CAP_RESET = 32'h01E8_0C80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cap,
    input  logic             wr_cur,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cap_q,
    output logic [REG_W-1:0] cur_q
);

    // Capability word: parameterised default, replaced by software writes
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_q <= CAP_RESET;
        else if (wr_cap) cap_q <= wdata;
    end

    // Maximum-current word: resets to zero
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_q <= '0;
        else if (wr_cur) cur_q <= wdata;
    end

endmodule

// File: rtl/sdglue_irq_track.sv
// Interrupt level tracker.
// Samples each slot's interrupt line into a status bit every cycle and merges
// the bits into one output. It assumes the lines are already synchronous to clk.
module sdglue_irq_track #(
    parameter int unsigned NUM_SLOTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] lvl_in,
    output logic [NUM_SLOTS-1:0] stat_q,
    output logic                 any_o
);

    // Status bits follow the input levels, one cycle behind
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= lvl_in;
    end

    // Merged request stays high while any status bit is set
    assign any_o = |stat_q;

endmodule

// File: rtl/sdhost_glue_regs.sv
// SD host wrapper register block (top).
// Decodes a 4 KiB register window. It holds the global registers and the
// per-slot exported words, raises the slot window selects and merges the slot
// interrupts. Every request that is not routed to a slot is answered one cycle
// later. It assumes at most one request per cycle and NUM_SLOTS of 1 or 2.
module sdhost_glue_regs
    import sdglue_pkg::*;
#(
    parameter int unsigned      NUM_SLOTS = 2,
    parameter logic [31:0]      CAP_RESET = 32'h01E8_0C80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [11:0]              req_addr,
    input  logic [31:0]              req_wdata,
    input  logic [3:0]               req_strb,
    output logic                     rsp_ready,
    output logic [31:0]              rsp_rdata,
    output logic                     rsp_err,
    output logic [NUM_SLOTS-1:0]     slot_sel,
    input  logic [NUM_SLOTS-1:0]     slot_irq,
    output logic                     irq_out,
    output logic                     host_rst_pulse,
    output logic [32*NUM_SLOTS-1:0]  slot_cap_o,
    output logic [32*NUM_SLOTS-1:0]  slot_cur_o,
    output logic [31:0]              cfg_debounce,
    output logic [31:0]              cfg_bus,
    output logic [31:0]              cfg_wp_pol,
    output logic [31:0]              cfg_card_det
);

    localparam logic [REG_W-1:0] PRESENCE = presence_bits(NUM_SLOTS);

    dec_t                 dec;
    logic [NUM_SLOTS-1:0] win_hit;
    logic                 to_slot;
    logic                 wr_ok;
    logic [REG_W-1:0]     info_q;
    logic [REG_W-1:0]     rd_mux;
    logic [NUM_SLOTS-1:0] irq_stat;
    logic [REG_W-1:0]     cap_w [NUM_SLOTS];
    logic [REG_W-1:0]     cur_w [NUM_SLOTS];

    sdglue_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
        .addr    (req_addr),
        .strb    (req_strb),
        .dec     (dec),
        .win_hit (win_hit)
    );

    // Slot selects follow the request combinationally
    assign slot_sel = req_valid ? win_hit : '0;
    assign to_slot  = (dec.tgt == TGT_SLOT);
    assign wr_ok    = req_valid && req_write && !dec.err;

    // One configuration holder per slot
    for (genvar g = 0; g < int'(NUM_SLOTS); g++) begin : g_slot
        sdglue_slot_cfg #(.CAP_RESET(CAP_RESET)) u_cfg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_cap (wr_ok && dec.tgt == TGT_CAP && dec.idx == IDX_W'(g)),
            .wr_cur (wr_ok && dec.tgt == TGT_CUR && dec.idx == IDX_W'(g)),
            .wdata  (req_wdata),
            .cap_q  (cap_w[g]),
            .cur_q  (cur_w[g])
        );
        assign slot_cap_o[g*32 +: 32] = cap_w[g];
        assign slot_cur_o[g*32 +: 32] = cur_w[g];
    end

    sdglue_irq_track #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (slot_irq),
        .stat_q (irq_stat),
        .any_o  (irq_out)
    );

    // Information register: only the writable bits are stored
    always_ff @(posedge clk) begin
        if (!rst_n)
            info_q <= '0;
        else if (wr_ok && dec.tgt == TGT_INFO)
            info_q <= req_wdata & ~INFO_RO_MASK;
    end

    // Reset request pulse, one cycle, aligned with the write response
    always_ff @(posedge clk) begin
        if (!rst_n) host_rst_pulse <= 1'b0;
        else        host_rst_pulse <= wr_ok && dec.tgt == TGT_INFO
                                      && req_wdata[INFO_RST_BIT];
    end

    // Plain read/write global settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_debounce <= DEB_RESET;
            cfg_bus      <= '0;
            cfg_wp_pol   <= '0;
            cfg_card_det <= '0;
        end else if (wr_ok) begin
            case (dec.tgt)
                TGT_DEB:   cfg_debounce <= req_wdata;
                TGT_BUS:   cfg_bus      <= req_wdata;
                TGT_WPPOL: cfg_wp_pol   <= req_wdata;
                TGT_CDET:  cfg_card_det <= req_wdata;
                default:   ;
            endcase
        end
    end

    // Read data selection from current state
    always_comb begin
        rd_mux = '0;
        case (dec.tgt)
            TGT_INFO:  rd_mux = info_q | PRESENCE;
            TGT_DEB:   rd_mux = cfg_debounce;
            TGT_BUS:   rd_mux = cfg_bus;
            TGT_WPPOL: rd_mux = cfg_wp_pol;
            TGT_CDET:  rd_mux = cfg_card_det;
            TGT_IRQST: rd_mux = REG_W'(irq_stat);
            TGT_CAP: begin
                for (int i = 0; i < int'(NUM_SLOTS); i++)
                    if (dec.idx == IDX_W'(i)) rd_mux = cap_w[i];
            end
            TGT_CUR: begin
                for (int i = 0; i < int'(NUM_SLOTS); i++)
                    if (dec.idx == IDX_W'(i)) rd_mux = cur_w[i];
            end
            default:   rd_mux = '0;
        endcase
    end

    // Registered response: ready, error and read data one cycle after request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ready <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_ready <= req_valid && !to_slot;
            rsp_err   <= req_valid && dec.err;
            rsp_rdata <= (req_valid && !req_write && !dec.err && !to_slot)
                         ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/sdglue_regs_chk.sv
// Property checker for the wrapper register block, bound to the top.
// It observes ports only and assumes a synchronous active-low reset.
module sdglue_regs_chk #(
    parameter int unsigned NUM_SLOTS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [11:0]          req_addr,
    input logic [31:0]          req_wdata,
    input logic [3:0]           req_strb,
    input logic                 rsp_ready,
    input logic [31:0]          rsp_rdata,
    input logic                 rsp_err,
    input logic [NUM_SLOTS-1:0] slot_sel,
    input logic [NUM_SLOTS-1:0] slot_irq,
    input logic                 irq_out,
    input logic                 host_rst_pulse,
    input logic [31:0]          cfg_debounce
);

    localparam logic [1:0] PRES_EXP = (NUM_SLOTS == 2) ? 2'b11 : 2'b01;

    // R1: debounce shows its reset value in the first cycle out of reset
    assert_debounce_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_debounce == 32'h0000_0005);

    // R3: a reset pulse only follows a full write of bit 0 to offset 0
    assert_pulse_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst_pulse |-> $past(req_valid && req_write && req_addr == 12'h000
                                 && req_strb == 4'hF && req_wdata[0]));

    // R4: presence flags always read as the slot count dictates
    assert_presence_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid && !req_write && req_addr == 12'h000
                               && req_strb == 4'hF))
        |-> rsp_rdata[17:16] == PRES_EXP);

    // R6: at most one slot selected
    assert_one_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_sel));

    // R6: slot-routed requests get no response from this block
    assert_slot_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_sel) |=> !rsp_ready);

    // R8: merged interrupt matches the lines seen one cycle before
    assert_irq_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> irq_out == (|$past(slot_irq)));

    // R9: partial-strobe requests are always rejected
    assert_partial_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_strb != 4'hF) |=> rsp_err);

    // R10: an error response carries zero data and a ready
    assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_ready && rsp_rdata == 32'h0));

    // R11: a non-slot request is answered in the next cycle
    assert_resp_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(|slot_sel)) |=> rsp_ready);

    // R11: no response without a request
    assert_no_stray_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ready);

endmodule

bind sdhost_glue_regs sdglue_regs_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .req_strb       (req_strb),
    .rsp_ready      (rsp_ready),
    .rsp_rdata      (rsp_rdata),
    .rsp_err        (rsp_err),
    .slot_sel       (slot_sel),
    .slot_irq       (slot_irq),
    .irq_out        (irq_out),
    .host_rst_pulse (host_rst_pulse),
    .cfg_debounce   (cfg_debounce)
);

// File: tb/sdhost_glue_regs_test.sv
`timescale 1ns/1ps
// Directed bench for the wrapper register block: one task per scenario.
module sdhost_glue_regs_test;

    localparam int unsigned NS  = 2;
    localparam logic [31:0] CAP = 32'h01E8_0C80;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [11:0]       req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [3:0]        req_strb = 4'hF;
    logic              rsp_ready;
    logic [31:0]       rsp_rdata;
    logic              rsp_err;
    logic [NS-1:0]     slot_sel;
    logic [NS-1:0]     slot_irq = '0;
    logic              irq_out;
    logic              host_rst_pulse;
    logic [32*NS-1:0]  slot_cap_o;
    logic [32*NS-1:0]  slot_cur_o;
    logic [31:0]       cfg_debounce, cfg_bus, cfg_wp_pol, cfg_card_det;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0]   r_data;
    logic          r_rdy, r_err, r_pulse;
    logic [NS-1:0] r_sel;

    always #2 clk = ~clk;

    sdhost_glue_regs #(.NUM_SLOTS(NS), .CAP_RESET(CAP)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .slot_sel(slot_sel), .slot_irq(slot_irq), .irq_out(irq_out),
        .host_rst_pulse(host_rst_pulse), .slot_cap_o(slot_cap_o),
        .slot_cur_o(slot_cur_o), .cfg_debounce(cfg_debounce), .cfg_bus(cfg_bus),
        .cfg_wp_pol(cfg_wp_pol), .cfg_card_det(cfg_card_det)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One request; results captured in the cycle after it
    task automatic bus_op(input logic wr, input logic [11:0] a,
                          input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_strb = s;
        #1;
        r_sel = slot_sel;
        @(posedge clk);
        #1;
        r_data = rsp_rdata; r_rdy = rsp_ready; r_err = rsp_err; r_pulse = host_rst_pulse;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        bus_op(1'b0, a, 32'h0, 4'hF);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_op(1'b1, a, d, 4'hF);
    endtask

    task automatic t_reset;
        rd(12'h000); check("R1", "info reset", r_data, 32'h0003_0000);
        rd(12'h004); check("R1", "debounce reset", r_data, 32'h5);
        rd(12'h008); check("R1", "bus reset", r_data, 0);
        rd(12'h0EC); check("R1", "wp reset", r_data, 0);
        rd(12'h0F0); check("R1", "cd reset", r_data, 0);
        rd(12'h0FC); check("R1", "irq stat reset", r_data, 0);
        rd(12'h010); check("R1", "cap0 reset", r_data, CAP);
        rd(12'h028); check("R1", "cur1 reset", r_data, 0);
        check("R1", "cap outputs", slot_cap_o, {CAP, CAP});
        check("R1", "irq_out reset", irq_out, 0);
    endtask

    task automatic t_rw;
        wr(12'h004, 32'hDEAD_BEEF); wr(12'h008, 32'hA5A5_5A5A);
        wr(12'h0EC, 32'hFFFF_FFFF); wr(12'h0F0, 32'h1234_5678);
        rd(12'h004); check("R2", "debounce rb", r_data, 32'hDEAD_BEEF);
        rd(12'h008); check("R2", "bus rb", r_data, 32'hA5A5_5A5A);
        rd(12'h0EC); check("R2", "wp rb", r_data, 32'hFFFF_FFFF);
        rd(12'h0F0); check("R2", "cd rb", r_data, 32'h1234_5678);
        check("R2", "cfg outs", {cfg_bus, cfg_card_det}, {32'hA5A5_5A5A, 32'h1234_5678});
    endtask

    task automatic t_info;
        wr(12'h000, 32'h0000_0001);
        check("R3", "pulse on bit0 write", r_pulse, 1);
        check("R11", "write resp", {r_rdy, r_err, r_data}, {1'b1, 1'b0, 32'h0});
        rd(12'h000);
        check("R3", "pulse single cycle", r_pulse, 0);
        check("R3", "bit0 reads zero", r_data, 32'h0003_0000);
        wr(12'h000, 32'h0000_0000);
        check("R3", "no pulse bit0 clear", r_pulse, 0);
        rd(12'h000); check("R4", "presence kept on zero write", r_data, 32'h0003_0000);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000); check("R4", "all ones write", r_data, 32'hFFFF_FFFE);
        wr(12'h000, 32'h0000_0000);
    endtask

    task automatic t_alias;
        wr(12'h010, 32'h1111_0001); wr(12'h018, 32'h2222_0002);
        wr(12'h020, 32'h3333_0003); wr(12'h028, 32'h4444_0004);
        rd(12'h010); check("R5", "cap0 rb", r_data, 32'h1111_0001);
        rd(12'h018); check("R5", "cur0 rb", r_data, 32'h2222_0002);
        rd(12'h020); check("R5", "cap1 rb", r_data, 32'h3333_0003);
        rd(12'h028); check("R5", "cur1 rb", r_data, 32'h4444_0004);
        check("R5", "cap out", slot_cap_o, {32'h3333_0003, 32'h1111_0001});
        check("R5", "cur out", slot_cur_o, {32'h4444_0004, 32'h2222_0002});
    endtask

    task automatic t_window;
        rd(12'h100);
        check("R6", "slot0 sel", r_sel, 2'b01);
        check("R6", "slot0 no rsp", r_rdy, 0);
        wr(12'h2FC, 32'hFFFF_FFFF);
        check("R6", "slot1 sel", r_sel, 2'b10);
        check("R6", "slot1 no rsp", r_rdy, 0);
        check("R6", "globals untouched", {slot_cap_o, cfg_bus},
              {32'h3333_0003, 32'h1111_0001, 32'hA5A5_5A5A});
        rd(12'h300);
        check("R10", "above windows", {r_sel, r_rdy, r_err, r_data},
              {2'b00, 1'b1, 1'b1, 32'h0});
    endtask

    task automatic t_irq;
        @(negedge clk); slot_irq = 2'b11;
        @(posedge clk); #1;
        check("R8", "irq both", irq_out, 1);
        rd(12'h0FC); check("R7", "stat both", r_data, 32'h3);
        @(negedge clk); slot_irq = 2'b10;
        @(posedge clk); #1;
        check("R8", "irq still one", irq_out, 1);
        wr(12'h0FC, 32'h0);
        check("R7", "stat write no err", r_err, 0);
        rd(12'h0FC); check("R7", "stat write ignored", r_data, 32'h2);
        @(negedge clk); slot_irq = 2'b00;
        @(posedge clk); #1;
        check("R8", "irq dropped", irq_out, 0);
        rd(12'h0FC); check("R7", "stat clear", r_data, 32'h0);
    endtask

    task automatic t_err;
        rd(12'h00C);
        check("R10", "undecoded read", {r_rdy, r_err, r_data}, {1'b1, 1'b1, 32'h0});
        wr(12'h030, 32'hFFFF_FFFF);
        check("R10", "undecoded write err", r_err, 1);
        rd(12'h030); check("R10", "undecoded stays zero", r_data, 0);
        bus_op(1'b1, 12'h004, 32'h0000_0000, 4'h3);
        check("R9", "partial write err", {r_rdy, r_err}, 2'b11);
        rd(12'h004); check("R9", "debounce unchanged", r_data, 32'hDEAD_BEEF);
        bus_op(1'b0, 12'h004, 32'h0, 4'h1);
        check("R9", "partial read", {r_err, r_data}, {1'b1, 32'h0});
        bus_op(1'b0, 12'h106, 32'h0, 4'hF);
        check("R9", "misaligned", {r_sel, r_err, r_data}, {2'b00, 1'b1, 32'h0});
        @(posedge clk); #1;
        check("R11", "idle no ready", {rsp_ready, rsp_err}, 2'b00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1 check("R1", "debounce out", cfg_debounce, 32'h5);
        t_reset();
        t_rw();
        t_info();
        t_alias();
        t_window();
        t_irq();
        t_err();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule